// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives a pulse-width-modulated output from a 10-bit duty value and an 8-bit period register. A free-running 8-bit timer, extended by two low-order fraction bits, forms a 10-bit time base. The fraction bits come from a quarter-cycle phase counter at prescale 1:1 and from the prescaler's top two bits at 1:4 or 1:16. The output goes high at the start of each period and drops when the time base reaches the active duty value.

Software writes the period, the duty upper byte, the duty low two bits and the prescale select through separate write strobes. Each write may land at any time. The duty value is staged and moves into an active buffer only at a period boundary, so a period never mixes an old and a new duty setting. A one-clock match pulse marks each period start.

Top module: `pwm10_gen`

## Requirements
- R1: After reset the output and the match pulse are low, the timer is zero, the active duty is zero and the period register holds 255.
- R2: The match pulse is one clock wide and successive pulses are (P+1)·4·N input clocks apart, where P is the period register and N is the prescale ratio.
- R3: The prescale select encodes 00 as 1:1, 01 as 1:4, and both 10 and 11 as 1:16.
- R4: The output rises only in the clock that carries the match pulse, and in that clock it is high exactly when the newly latched duty is nonzero.
- R5: The duty value D is {upper byte, low field}, with the 2-bit field in bits 1:0. With D below 4·(P+1) and nonzero, the output is high for D·N clocks per period.
- R6: With a duty of zero the output stays low for the whole period.
- R7: With D of 4·(P+1) or more the output stays high for the whole period.
- R8: A duty write during a period leaves that period unchanged and takes effect from the next match. The active duty changes only in the clock that carries the match pulse.
- R9: In the match clock the timer is zero, and between matches it only holds or steps by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_we_i | input | 1 | Period register write strobe |
| period_i | input | 8 | Period register value |
| duty_hi_we_i | input | 1 | Duty upper byte write strobe |
| duty_hi_i | input | 8 | Duty bits 9:2 |
| duty_lo_we_i | input | 1 | Duty low field write strobe |
| duty_lo_i | input | 2 | Duty bits 1:0 |
| pre_we_i | input | 1 | Prescale select write strobe |
| pre_sel_i | input | 2 | Prescale select: 00 1:1, 01 1:4, 1x 1:16 |
| pwm_o | output | 1 | PWM output |
| match_o | output | 1 | One-clock pulse at each period start |

## Verification
The bench runs duty values with nonzero low bits at all three prescale ratios and at both 1:16 encodings. Measured high time and period then expose a dropped fraction bit, a wrong shift of the prescaler bits or a misdecoded select. A zero duty, a duty just under the period length and a duty beyond it separate the zero-duty suppression, the last-clock clear and the stay-high case. A duty rewrite a few clocks into a period shows whether the staged value leaks into the running period. A behavioural reference is compared with both outputs on every clock.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV4   = 2'b01,
    PRE_DIV16  = 2'b10,
    PRE_DIV16B = 2'b11
  } pre_sel_e;

  // log2 of the ratio step between adjacent prescale settings
  localparam int unsigned PRE_STEP = 2;
endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler
  import pwm10_pkg::*;
#(
  parameter int unsigned FRAC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pre_sel_e          pre_sel_i,
  output logic              tick_o,
  output logic [FRAC_W-1:0] frac_nxt_o
);
  localparam int unsigned SUB_W = FRAC_W + 2 * PRE_STEP;
  localparam int unsigned SH_W  = $clog2(SUB_W + 1);

  logic [SUB_W-1:0] sub_q, sub_nxt, lim;
  logic [SH_W-1:0]  sh;

  always_comb begin
    unique case (pre_sel_i)
      PRE_DIV1: sh = '0;
      PRE_DIV4: sh = SH_W'(PRE_STEP);
      default:  sh = SH_W'(2 * PRE_STEP);
    endcase
  end

  // terminal count = 2**(FRAC_W+sh) - 1; >= tolerates a select change mid-count
  assign lim     = {SUB_W{1'b1}} >> (SH_W'(2 * PRE_STEP) - sh);
  assign tick_o  = (sub_q >= lim);
  assign sub_nxt = tick_o ? '0 : sub_q + 1'b1;
  assign frac_nxt_o = FRAC_W'(sub_nxt >> sh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sub_q <= '0;
    else         sub_q <= sub_nxt;
  end
endmodule

// File: rtl/pwm10_timer.sv
module pwm10_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] tmr_o,
  output logic [CNT_W-1:0] tmr_nxt_o
);
  logic [CNT_W-1:0] tmr_q;

  assign wrap_o = tick_i && (tmr_q == period_i);

  always_comb begin
    if (wrap_o)      tmr_nxt_o = '0;
    else if (tick_i) tmr_nxt_o = tmr_q + 1'b1;
    else             tmr_nxt_o = tmr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= tmr_nxt_o;
  end

  assign tmr_o = tmr_q;
endmodule

// File: rtl/pwm10_duty_buf.sv
module pwm10_duty_buf #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hi_we_i,
  input  logic [CNT_W-1:0]        hi_i,
  input  logic                    lo_we_i,
  input  logic [FRAC_W-1:0]       lo_i,
  input  logic                    load_i,
  output logic [CNT_W+FRAC_W-1:0] duty_new_o,
  output logic [CNT_W+FRAC_W-1:0] duty_act_o
);
  logic [CNT_W-1:0]        hi_q;
  logic [FRAC_W-1:0]       lo_q;
  logic [CNT_W+FRAC_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      act_q <= '0;
    end else begin
      if (hi_we_i) hi_q <= hi_i;
      if (lo_we_i) lo_q <= lo_i;
      if (load_i)  act_q <= {hi_q, lo_q};
    end
  end

  assign duty_new_o = {hi_q, lo_q};
  assign duty_act_o = act_q;
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              period_we_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              duty_hi_we_i,
  input  logic [CNT_W-1:0]  duty_hi_i,
  input  logic              duty_lo_we_i,
  input  logic [FRAC_W-1:0] duty_lo_i,
  input  logic              pre_we_i,
  input  logic [1:0]        pre_sel_i,
  output logic              pwm_o,
  output logic              match_o
);
  localparam int unsigned DUTY_W = CNT_W + FRAC_W;

  logic [CNT_W-1:0]  period_q;
  pre_sel_e          pre_q;
  logic              tick, wrap;
  logic [FRAC_W-1:0] frac_nxt;
  logic [CNT_W-1:0]  tmr_w, tmr_nxt;
  logic [DUTY_W-1:0] duty_new, duty_act_w, tb_nxt;
  logic              pwm_q, pwm_d, match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      pre_q    <= PRE_DIV1;
    end else begin
      if (period_we_i) period_q <= period_i;
      if (pre_we_i)    pre_q    <= pre_sel_e'(pre_sel_i);
    end
  end

  pwm10_prescaler #(.FRAC_W(FRAC_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_sel_i  (pre_q),
    .tick_o     (tick),
    .frac_nxt_o (frac_nxt)
  );

  pwm10_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .period_i  (period_q),
    .wrap_o    (wrap),
    .tmr_o     (tmr_w),
    .tmr_nxt_o (tmr_nxt)
  );

  pwm10_duty_buf #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_duty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_we_i    (duty_hi_we_i),
    .hi_i       (duty_hi_i),
    .lo_we_i    (duty_lo_we_i),
    .lo_i       (duty_lo_i),
    .load_i     (wrap),
    .duty_new_o (duty_new),
    .duty_act_o (duty_act_w)
  );

  // compare the time base of the coming clock so the registered output is high D*N clocks
  assign tb_nxt = {tmr_nxt, frac_nxt};

  always_comb begin
    pwm_d = pwm_q;
    if (wrap)                      pwm_d = |duty_new;
    else if (tb_nxt == duty_act_w) pwm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pwm_q   <= pwm_d;
      match_q <= wrap;
    end
  end

  assign pwm_o   = pwm_q;
  assign match_o = match_q;
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    pwm_i,
  input logic                    match_i,
  input logic [CNT_W-1:0]        tmr_i,
  input logic [CNT_W+FRAC_W-1:0] duty_act_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (!pwm_i && !match_i && tmr_i == '0 && duty_act_i == '0)
        else $error("reset state wrong");
    end
  end

  assert_match_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> !match_i);

  assert_rise_at_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_i) |-> match_i);

  assert_set_on_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> (pwm_i == (duty_act_i != '0)));

  assert_zero_duty_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act_i == '0) |-> !pwm_i);

  assert_duty_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |-> $stable(duty_act_i));

  assert_timer_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> (tmr_i == '0));

  assert_timer_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |-> (tmr_i == $past(tmr_i) || tmr_i == CNT_W'($past(tmr_i) + 1'b1)));
endmodule

bind pwm10_gen pwm10_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwm_i      (pwm_o),
  .match_i    (match_o),
  .tmr_i      (tmr_w),
  .duty_act_i (duty_act_w)
);

// File: tb/tb_pwm10_gen.sv
module tb_pwm10_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       period_we_i = 1'b0;
  logic [7:0] period_i = '0;
  logic       duty_hi_we_i = 1'b0;
  logic [7:0] duty_hi_i = '0;
  logic       duty_lo_we_i = 1'b0;
  logic [1:0] duty_lo_i = '0;
  logic       pre_we_i = 1'b0;
  logic [1:0] pre_sel_i = '0;
  logic       pwm_o, match_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pwm10_gen dut (
    .clk_i, .rst_ni, .period_we_i, .period_i, .duty_hi_we_i, .duty_hi_i,
    .duty_lo_we_i, .duty_lo_i, .pre_we_i, .pre_sel_i, .pwm_o, .match_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_per, m_hi, m_lo, m_sel, m_sub, m_tmr, m_act;
  bit m_pwm, m_match;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_per = 255; m_hi = 0; m_lo = 0; m_sel = 0;
      m_sub = 0; m_tmr = 0; m_act = 0; m_pwm = 0; m_match = 0;
    end else begin
      int lim, sh, nsub, ntmr, ntb, newd;
      bit tk, bnd;
      sh   = (m_sel >= 2) ? 4 : (m_sel == 1) ? 2 : 0;
      lim  = (4 << sh) - 1;
      tk   = (m_sub >= lim);
      nsub = tk ? 0 : m_sub + 1;
      bnd  = tk && (m_tmr == m_per);
      ntmr = bnd ? 0 : tk ? (m_tmr + 1) % 256 : m_tmr;
      ntb  = ntmr * 4 + ((nsub >> sh) % 4);
      newd = m_hi * 4 + m_lo;
      if (bnd) begin
        m_pwm = (newd != 0);
        m_act = newd;
      end else if (ntb == m_act) m_pwm = 0;
      m_match = bnd;
      m_sub = nsub;
      m_tmr = ntmr;
      if (period_we_i)  m_per = period_i;
      if (duty_hi_we_i) m_hi  = duty_hi_i;
      if (duty_lo_we_i) m_lo  = duty_lo_i;
      if (pre_we_i)     m_sel = pre_sel_i;
    end
  end

  // per-clock comparison and period/high-time measurement
  int cnt = 0, hcnt = 0, last_per = 0, last_hi = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(pwm_o == m_pwm, "R4/R5 pwm_o vs model", pwm_o, m_pwm);
      chk(match_o == m_match, "R2 match_o vs model", match_o, m_match);
      if (match_o) begin
        last_per = cnt; last_hi = hcnt;
        cnt = 1; hcnt = int'(pwm_o);
      end else begin
        cnt++; hcnt += int'(pwm_o);
      end
    end
  end

  task automatic wait_match();
    do @(negedge clk_i); while (!match_o);
    #1;
  endtask

  task automatic write_cfg(input int p, input int hi, input int lo, input int sel);
    period_i = 8'(p); duty_hi_i = 8'(hi); duty_lo_i = 2'(lo); pre_sel_i = 2'(sel);
    period_we_i = 1; duty_hi_we_i = 1; duty_lo_we_i = 1; pre_we_i = 1;
    @(negedge clk_i); #1;
    period_we_i = 0; duty_hi_we_i = 0; duty_lo_we_i = 0; pre_we_i = 0;
  endtask

  task automatic run_case(input string req, input int p, input int hi, input int lo,
                          input int sel, input int ratio);
    int d, per_exp, hi_exp;
    wait_match();
    write_cfg(p, hi, lo, sel);
    wait_match();
    wait_match();
    d = hi * 4 + lo;
    per_exp = (p + 1) * 4 * ratio;
    hi_exp = (d == 0) ? 0 : (d * ratio >= per_exp) ? per_exp : d * ratio;
    chk(last_per == per_exp, {req, " R2 period"}, last_per, per_exp);
    chk(last_hi == hi_exp, {req, " high time"}, last_hi, hi_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pwm_o == 1'b0, "R1 reset pwm_o", pwm_o, 0);
    chk(match_o == 1'b0, "R1 reset match_o", match_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(pwm_o == 1'b0, "R1 after reset pwm_o", pwm_o, 0);
    // R1: default period 255 at 1:1, zero duty
    wait_match();
    wait_match();
    chk(last_per == 1024, "R1 default period", last_per, 1024);
    chk(last_hi == 0, "R1 default duty zero", last_hi, 0);

    run_case("R5 1:1 D=21",        9, 5, 1, 0, 1);
    run_case("R5 1:4 D=11",        4, 2, 3, 1, 4);
    run_case("R3 R5 1:16 sel10",   2, 1, 2, 2, 16);
    run_case("R3 R5 1:16 sel11",   1, 0, 3, 3, 16);
    run_case("R6 zero duty",       3, 0, 0, 0, 1);
    run_case("R7 duty over period",3, 10, 0, 0, 1);
    run_case("R5 last-clock clear",3, 3, 3, 0, 1);
    run_case("R5 1:4 D=1",         5, 0, 1, 1, 4);

    // R8: mid-period rewrite
    run_case("R8 base D=8",        9, 2, 0, 0, 1);
    wait_match();
    repeat (3) @(negedge clk_i);
    #1;
    duty_hi_i = 8'd7; duty_lo_i = 2'd2; duty_hi_we_i = 1; duty_lo_we_i = 1;
    @(negedge clk_i); #1;
    duty_hi_we_i = 0; duty_lo_we_i = 0;
    wait_match();
    chk(last_hi == 8, "R8 running period keeps old duty", last_hi, 8);
    wait_match();
    chk(last_hi == 30, "R8 next period uses new duty", last_hi, 30);
    chk(last_per == 40, "R8 period unchanged", last_per, 40);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule